// File: doc/BRIEF.md
# Holdover Frequency Selector

This block supplies the frequency word that a digital PLL runs on while it has no usable reference. All frequency words are two's-complement offsets from the nominal local oscillator frequency. The block watches the integral-path word of the loop, and only that word. From it the block keeps two estimates of the recent frequency. The first is a short history of snapshots that is always between one and two snapshot periods old. The second is an average taken over a full one-second window while the loop is locked.

On a one-cycle holdover-entry strobe, the block latches one of three candidates into its output register. In free-run mode the candidate is the programmed master-clock offset, so the oscillator runs at nominal plus that offset. In automatic mode with averaging requested, the candidate is the one-second average. If no average exists yet, it falls back to the delayed snapshot. In automatic mode without averaging, the candidate is the delayed snapshot. The output then holds until the next strobe. A sticky ready flag reports that a complete average has been formed, and software clears it with a clear pulse.

Top module: `hofs_top`

## Requirements
- R1: While reset is high and in the cycle that follows, `ho_freq` is 0 and `ho_ready` is 0.
- R2: A snapshot of `integ_freq` is taken on every SNAP_MS-th `tick_1ms` (default 50) and shifted through a two-entry pipeline. In automatic mode with `avg_en`=0, a strobe latches the older entry, which is between SNAP_MS and 2·SNAP_MS ticks old.
- R3: While `locked` is 1, each tick adds `integ_freq` to a window sum. On the AVG_LEN-th tick (default 1000), the average is computed as sum/AVG_LEN rounded to the nearest integer. In automatic mode with `avg_en`=1, a strobe latches this average.
- R4: While `locked` is 0, the window sum and its sample count are cleared, so samples taken before a loss of lock never enter a later average.
- R5: `ho_ready` becomes 1 in the cycle after a window completes and stays 1 until a `rdy_clr` pulse. Completion wins over a simultaneous clear. Clearing the flag does not change which value a later strobe selects.
- R6: When `avg_en`=1 but no window has completed since reset, a strobe latches the delayed snapshot of R2.
- R7: With `mode_fr`=1, a strobe latches `mclk_off` sign-extended to the output width, whatever the value of `avg_en`.
- R8: `ho_freq` changes only in the cycle after `ho_enter` is 1. At all other times it holds, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| locked | input | 1 | Loop is in its locked state |
| ho_enter | input | 1 | One-cycle holdover-entry strobe |
| mode_fr | input | 1 | 1: free-run holdover, 0: automatic holdover |
| avg_en | input | 1 | Automatic mode: use the one-second average |
| rdy_clr | input | 1 | Clears the ready flag |
| integ_freq | input | FW | Integral-path frequency word (signed) |
| mclk_off | input | OW | Master-clock offset word (signed) |
| ho_freq | output | FW | Holdover frequency word (signed) |
| ho_ready | output | 1 | Sticky flag: a full average is available |

## Verification
The assertions assume that `tick_1ms` is a single-cycle pulse. They also assume that `rdy_clr` is only ever meant to take effect in a cycle without a tick, so a clear never competes with window completion in the checked case. The stimulus spaces ticks four clocks apart and drives every control input on the falling edge, away from tick cycles. It changes `locked` only between ticks, so window boundaries fall on exact tick counts that the bench can predict. The sample values are chosen so that every expected average is an exact integer. The snapshot cases land a change of input between snapshot instants, so that both ends of the age window are exercised.

// File: rtl/hofs_pkg.sv
package hofs_pkg;

    typedef enum logic [1:0] {
        SRC_SNAP = 2'd0,
        SRC_AVG  = 2'd1,
        SRC_FREE = 2'd2
    } hofs_src_e;

    // Source priority: free-run overrides everything, then the average if one exists.
    function automatic hofs_src_e pick_src(input logic free_run,
                                           input logic want_avg,
                                           input logic avg_ok);
        if (free_run)
            return SRC_FREE;
        else if (want_avg && avg_ok)
            return SRC_AVG;
        else
            return SRC_SNAP;
    endfunction

endpackage

// File: rtl/hofs_snap_pipe.sv
module hofs_snap_pipe #(
    parameter int FW      = 24,
    parameter int SNAP_MS = 50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic signed [FW-1:0] freq_in,
    output logic signed [FW-1:0] snap_old
);
    localparam int SW = (SNAP_MS > 1) ? $clog2(SNAP_MS) : 1;
    localparam logic [SW-1:0] LAST = SW'(SNAP_MS - 1);

    logic [SW-1:0]         ms_cnt;
    logic signed [FW-1:0]  snap_new;

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_cnt   <= '0;
            snap_new <= '0;
            snap_old <= '0;
        end else if (tick) begin
            if (ms_cnt == LAST) begin
                ms_cnt   <= '0;
                snap_old <= snap_new;
                snap_new <= freq_in;
            end else begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hofs_avg.sv
module hofs_avg #(
    parameter int FW        = 24,
    parameter int AVG_LEN   = 1000,
    parameter int DIV_SHIFT = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 locked,
    input  logic                 rdy_clr,
    input  logic signed [FW-1:0] freq_in,
    output logic signed [FW-1:0] avg_word,
    output logic                 avg_ok,
    output logic                 ready
);
    localparam int CW = $clog2(AVG_LEN);
    localparam int AW = FW + CW + 1;
    localparam int PW = AW + 64;
    localparam longint unsigned RECIP =
        ((64'd1 << DIV_SHIFT) + 64'(AVG_LEN) - 64'd1) / 64'(AVG_LEN);
    localparam logic [CW-1:0] LAST = CW'(AVG_LEN - 1);

    logic [CW-1:0]         n_cnt;
    logic signed [AW-1:0]  acc;
    logic signed [AW-1:0]  sum_next;
    logic signed [PW-1:0]  sum_w;
    logic signed [PW-1:0]  rec_w;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  rounded;
    logic signed [FW-1:0]  quot;

    // Division by AVG_LEN as multiply by a ceiling reciprocal, rounded to nearest.
    always_comb begin
        sum_next = acc + AW'(freq_in);
        sum_w    = PW'(sum_next);
        rec_w    = PW'(RECIP);
        prod     = sum_w * rec_w;
        rounded  = (prod + (PW'(1) <<< (DIV_SHIFT - 1))) >>> DIV_SHIFT;
        quot     = rounded[FW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            n_cnt    <= '0;
            avg_word <= '0;
            avg_ok   <= 1'b0;
            ready    <= 1'b0;
        end else begin
            if (rdy_clr)
                ready <= 1'b0;
            if (!locked) begin
                acc   <= '0;
                n_cnt <= '0;
            end else if (tick) begin
                if (n_cnt == LAST) begin
                    acc      <= '0;
                    n_cnt    <= '0;
                    avg_word <= quot;
                    avg_ok   <= 1'b1;
                    ready    <= 1'b1;
                end else begin
                    acc   <= sum_next;
                    n_cnt <= n_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hofs_select.sv
module hofs_select
    import hofs_pkg::*;
#(
    parameter int FW = 24,
    parameter int OW = 16
) (
    input  logic                 mode_fr,
    input  logic                 avg_en,
    input  logic                 avg_ok,
    input  logic signed [FW-1:0] snap_word,
    input  logic signed [FW-1:0] avg_word,
    input  logic signed [OW-1:0] off_word,
    output logic signed [FW-1:0] pick_word
);
    hofs_src_e src;

    always_comb begin
        src = pick_src(mode_fr, avg_en, avg_ok);
        unique case (src)
            SRC_FREE: pick_word = FW'(off_word);
            SRC_AVG:  pick_word = avg_word;
            default:  pick_word = snap_word;
        endcase
    end

endmodule

// File: rtl/hofs_top.sv
module hofs_top #(
    parameter int FW        = 24,
    parameter int OW        = 16,
    parameter int SNAP_MS   = 50,
    parameter int AVG_LEN   = 1000,
    parameter int DIV_SHIFT = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_1ms,
    input  logic          locked,
    input  logic          ho_enter,
    input  logic          mode_fr,
    input  logic          avg_en,
    input  logic          rdy_clr,
    input  logic [FW-1:0] integ_freq,
    input  logic [OW-1:0] mclk_off,
    output logic [FW-1:0] ho_freq,
    output logic          ho_ready
);
    logic signed [FW-1:0] snap_dly;
    logic signed [FW-1:0] avg_word;
    logic signed [FW-1:0] pick_word;
    logic                 avg_ok;

    hofs_snap_pipe #(.FW(FW), .SNAP_MS(SNAP_MS)) u_snap (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1ms),
        .freq_in  ($signed(integ_freq)),
        .snap_old (snap_dly)
    );

    hofs_avg #(.FW(FW), .AVG_LEN(AVG_LEN), .DIV_SHIFT(DIV_SHIFT)) u_avg (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1ms),
        .locked   (locked),
        .rdy_clr  (rdy_clr),
        .freq_in  ($signed(integ_freq)),
        .avg_word (avg_word),
        .avg_ok   (avg_ok),
        .ready    (ho_ready)
    );

    hofs_select #(.FW(FW), .OW(OW)) u_sel (
        .mode_fr   (mode_fr),
        .avg_en    (avg_en),
        .avg_ok    (avg_ok),
        .snap_word (snap_dly),
        .avg_word  (avg_word),
        .off_word  ($signed(mclk_off)),
        .pick_word (pick_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ho_freq <= '0;
        else if (ho_enter)
            ho_freq <= pick_word;
    end

endmodule

// File: rtl/hofs_chk.sv
module hofs_chk #(
    parameter int FW = 24,
    parameter int OW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_1ms,
    input logic          locked,
    input logic          ho_enter,
    input logic          mode_fr,
    input logic          rdy_clr,
    input logic [OW-1:0] mclk_off,
    input logic [FW-1:0] ho_freq,
    input logic          ho_ready,
    input logic [FW-1:0] snap_dly
);
    logic [FW-1:0] off_ext;
    assign off_ext = {{(FW-OW){mclk_off[OW-1]}}, mclk_off};

    // R8: output holds unless a strobe was seen
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        !ho_enter |=> $stable(ho_freq));

    // R7: free-run strobe loads the extended offset
    a_r7_free_run: assert property (@(posedge clk) disable iff (rst)
        (ho_enter && mode_fr) |=> (ho_freq == $past(off_ext)));

    // R5: a clear without a completing tick drops the flag
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (rdy_clr && !tick_1ms) |=> !ho_ready);

    // R5: the flag only rises after a locked tick
    a_r5_rise_src: assert property (@(posedge clk) disable iff (rst)
        $rose(ho_ready) |-> $past(tick_1ms && locked));

    // R2: the delayed snapshot moves only on ticks
    a_r2_snap_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_1ms |=> $stable(snap_dly));

endmodule

bind hofs_top hofs_chk #(.FW(FW), .OW(OW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_1ms (tick_1ms),
    .locked   (locked),
    .ho_enter (ho_enter),
    .mode_fr  (mode_fr),
    .rdy_clr  (rdy_clr),
    .mclk_off (mclk_off),
    .ho_freq  (ho_freq),
    .ho_ready (ho_ready),
    .snap_dly (snap_dly)
);

// File: tb/test_hofs_top.sv
module test_hofs_top;
    localparam int FW = 24;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_1ms = 1'b0;
    logic          locked = 1'b0;
    logic          ho_enter = 1'b0;
    logic          mode_fr = 1'b0;
    logic          avg_en = 1'b0;
    logic          rdy_clr = 1'b0;
    logic [FW-1:0] integ_freq = '0;
    logic [OW-1:0] mclk_off = '0;
    logic [FW-1:0] ho_freq;
    logic          ho_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [FW-1:0] exp_q[$];
    string         tag_q[$];
    logic          ent_q = 1'b0;

    always #10 clk = ~clk;

    hofs_top i_hofs_top (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .locked(locked),
        .ho_enter(ho_enter), .mode_fr(mode_fr), .avg_en(avg_en),
        .rdy_clr(rdy_clr), .integ_freq(integ_freq), .mclk_off(mclk_off),
        .ho_freq(ho_freq), .ho_ready(ho_ready)
    );

    function automatic logic [FW-1:0] w(input int v);
        return FW'(v);
    endfunction

    task automatic check(input string req, input logic [FW-1:0] act,
                         input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req,
                     $signed(act), $signed(exp));
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_1ms = 1'b1;
            @(negedge clk) tick_1ms = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // Driver: predicts the latched word and pulses the strobe
    task automatic enter(input string req, input logic [FW-1:0] exp);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        ho_enter = 1'b1;
        @(negedge clk) ho_enter = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) ent_q <= ho_enter;

    // Monitor: compares each latched word against the queue
    always @(negedge clk) begin
        if (ent_q) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8: actual unexpected update expected none");
            end else begin
                check(tag_q.pop_front(), ho_freq, exp_q.pop_front());
            end
        end
    end

    initial begin
        logic [FW-1:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset freq", ho_freq, '0);
        check("R1 reset ready", FW'(ho_ready), '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", ho_freq, '0);

        // R6 fallback and R2 delay window
        avg_en = 1'b1;
        integ_freq = w(1000);
        ticks(150);
        integ_freq = w(-2000);
        ticks(50);
        enter("R6 fallback to snapshot", w(1000));
        enter("R2 at least one period old", w(1000));
        avg_en = 1'b0;
        ticks(90);
        enter("R2 at most two periods old", w(-2000));

        // R8 freeze
        held = ho_freq;
        integ_freq = w(777);
        mode_fr = 1'b1;
        mclk_off = 16'h0123;
        ticks(120);
        check("R8 frozen without strobe", ho_freq, held);
        mode_fr = 1'b0;

        // R4 restart on loss of lock, R3 average
        integ_freq = w(9999);
        locked = 1'b1;
        ticks(300);
        locked = 1'b0;
        repeat (3) @(negedge clk);
        integ_freq = w(123456);
        locked = 1'b1;
        ticks(999);
        check("R5 not ready before window end", FW'(ho_ready), '0);
        ticks(1);
        check("R5 ready after window", FW'(ho_ready), w(1));
        avg_en = 1'b1;
        enter("R4 R3 average after restart", w(123456));

        // R3 mixed window
        locked = 1'b0;
        @(negedge clk);
        locked = 1'b1;
        integ_freq = w(-70000);
        ticks(500);
        integ_freq = w(50002);
        ticks(500);
        enter("R3 mixed average", w(-9999));

        // R5 clear does not change selection
        @(negedge clk) rdy_clr = 1'b1;
        @(negedge clk) rdy_clr = 1'b0;
        check("R5 cleared", FW'(ho_ready), '0);
        ticks(20);
        check("R5 stays cleared", FW'(ho_ready), '0);
        enter("R5 average still used", w(-9999));

        // R7 free run ignores avg_en
        mode_fr = 1'b1;
        mclk_off = 16'hFED4;
        enter("R7 negative offset", w(-300));
        avg_en = 1'b0;
        mclk_off = 16'h7FFF;
        enter("R7 positive offset", w(32767));

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R8: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule